// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and takes the memory from a cold start to a state where normal traffic may begin. After reset it keeps the clock-enable pin low and the command bus quiet for a stable-power interval. It then walks a fixed series of commands:

- a NOP with clock enable raised;
- a precharge of all banks;
- an extended-mode load that enables the DLL;
- a base-mode load that resets the DLL;
- a second all-bank precharge;
- two auto refreshes;
- a final base-mode load with the DLL reset bit cleared.

Every wait between commands is a parameter given in clock cycles. Every idle cycle carries a NOP. Both mode register values are parameters.

Two flags leave the block. `init_done` marks the end of the series. `read_ok` tells the read scheduler that enough cycles have elapsed since the DLL reset for a READ to be legal. The two flags are independent. With short command gaps, `init_done` may rise well before `read_ok`.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset and for `T_PWR` cycles after reset is released, `cke` is 0 and the command {cs_n,ras_n,cas_n,we_n} is NOP = 4'b0111.
- R2: In cycle `T_PWR` (counting the first cycle after reset release as 0) `cke` goes to 1 with a NOP, and `cke` remains 1 until the next reset.
- R3: In cycle `T_PWR+1` a PRECHARGE (4'b0010) is issued with addr[10]=1, all other address bits 0 and ba=0.
- R4: `T_RP` cycles after the first precharge, LOAD MODE (4'b0000) is issued with ba=2'b01 and addr=`EMR_VAL`.
- R5: `T_MRD` cycles later, LOAD MODE is issued with ba=2'b00 and addr=`MR_VAL` with bit 8 forced to 1 (DLL reset).
- R6: `read_ok` is 0 until exactly `T_DLL` cycles after the DLL-reset load cycle, then 1 until the next reset.
- R7: `T_MRD` cycles after the DLL-reset load, a second PRECHARGE with addr[10]=1 is issued.
- R8: `T_RP` cycles after the second precharge, AUTO REFRESH (4'b0001) is issued. A second AUTO REFRESH follows `T_RFC` cycles later, and there are exactly two.
- R9: `T_RFC` cycles after the second refresh, LOAD MODE is issued with ba=2'b00 and addr=`MR_VAL` with bit 8 forced to 0. `init_done` rises `T_MRD` cycles after that.
- R10: Every cycle that carries none of the commands above carries NOP, with ba=0 and addr=0.
- R11: `init_done` stays 1 with NOP on the bus until the next reset.
- R12: Reset asserted at any point restarts the whole sequence from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus / mode register value |
| init_done | output | 1 | Sequence complete |
| read_ok | output | 1 | DLL lock window elapsed; READ permitted |

## Verification
A wrong state or gap counter shows at the ports as a command that arrives a cycle early or late, or on the wrong bank or address. It can also show as a non-NOP code in a cycle that should be idle. Each of these is visible in the very cycle it happens. The bench therefore compares every bus field in every cycle against a timeline derived from the parameters. A fault in the DLL window counter surfaces only at the `read_ok` edge, `T_DLL` cycles after the DLL-reset load. Randomly placed resets show whether any counter or flag survives a restart.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int ADDR_W = 13,
  parameter int T_PWR  = 20000,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 15,
  parameter int T_DLL  = 200,
  parameter logic [ADDR_W-1:0] EMR_VAL = '0,
  parameter logic [ADDR_W-1:0] MR_VAL  = ADDR_W'(12'h062)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              read_ok
);
  localparam int G1   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int G2   = (G1 > T_RFC) ? G1 : T_RFC;
  localparam int TMAX = (G2 > T_PWR) ? G2 : T_PWR;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int DW   = $clog2(T_DLL + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [3:0] {
    S_PWR, S_NOP, S_PRE1, S_EMR, S_MRR, S_PRE2, S_REF1, S_REF2, S_MRS, S_DONE
  } st_t;

  st_t          st;
  logic         hold;
  logic [CW-1:0] cnt;
  logic         armed;
  logic [DW-1:0] dcnt;
  int           gap;
  logic [3:0]   cmd;

  always_comb begin
    case (st)
      S_PRE1, S_PRE2:      gap = T_RP;
      S_EMR, S_MRR, S_MRS: gap = T_MRD;
      S_REF1, S_REF2:      gap = T_RFC;
      default:             gap = 1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_PWR;
      hold <= 1'b1;
      cnt  <= CW'(T_PWR - 1);
    end else if (st != S_DONE) begin
      if (hold) begin
        if (cnt == '0) begin
          hold <= 1'b0;
          st   <= st_t'(st + 4'd1);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (gap > 1) begin
        hold <= 1'b1;
        cnt  <= CW'(gap - 2);
      end else begin
        st <= st_t'(st + 4'd1);
      end
    end
  end

  // R6: DLL lock window, opened by the DLL-reset load cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      dcnt  <= '0;
    end else if (st == S_MRR && !hold) begin
      armed <= 1'b1;
      dcnt  <= DW'(T_DLL - 1);
    end else if (armed && dcnt != '0) begin
      dcnt <= dcnt - 1'b1;
    end
  end

  always_comb begin
    cmd  = C_NOP;
    ba   = 2'b00;
    addr = '0;
    if (!hold) begin
      case (st)
        S_PRE1, S_PRE2: begin cmd = C_PRE; addr[10] = 1'b1; end
        S_EMR:          begin cmd = C_LMR; ba = 2'b01; addr = EMR_VAL; end
        S_MRR:          begin cmd = C_LMR; addr = MR_VAL; addr[8] = 1'b1; end
        S_REF1, S_REF2: cmd = C_REF;
        S_MRS:          begin cmd = C_LMR; addr = MR_VAL; addr[8] = 1'b0; end
        default:        cmd = C_NOP;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = (st != S_PWR);
  assign init_done = (st == S_DONE);
  assign read_ok   = armed && (dcnt == '0);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              read_ok
);
  logic [3:0] c;
  assign c = {cs_n, ras_n, cas_n, we_n};

  p_quiet_low_cke_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> c == 4'b0111);
  p_cke_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c == 4'b0010 |-> addr[10]);
  p_read_ok_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |=> read_ok);
  p_done_needs_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> cke);
  p_done_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  p_idle_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> c == 4'b0111);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 13;
  localparam int P    = 37;
  localparam int TRP  = 3;
  localparam int TMRD = 2;
  localparam int TRFC = 9;
  localparam int TDLL = 200;
  localparam logic [AW-1:0] EMR = 13'h040;
  localparam logic [AW-1:0] MR  = 13'h062;

  localparam int T_NOP  = P;
  localparam int T_PRE1 = P + 1;
  localparam int T_EMR  = T_PRE1 + TRP;
  localparam int T_MRR  = T_EMR + TMRD;
  localparam int T_PRE2 = T_MRR + TMRD;
  localparam int T_REF1 = T_PRE2 + TRP;
  localparam int T_REF2 = T_REF1 + TRFC;
  localparam int T_MRS  = T_REF2 + TRFC;
  localparam int T_DONE = T_MRS + TMRD;
  localparam int T_RDOK = T_MRR + TDLL;
  localparam int FULL   = T_RDOK + 20;

  logic clk = 0, rst_n = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, read_ok;
  logic [1:0] ba;
  logic [AW-1:0] addr;
  int checks = 0, failures = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_seq #(.ADDR_W(AW), .T_PWR(P), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
                 .T_DLL(TDLL), .EMR_VAL(EMR), .MR_VAL(MR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done), .read_ok(read_ok));

  function automatic string tag_of(int k);
    if (k < T_NOP)  return "R1";
    if (k == T_NOP) return "R2";
    if (k == T_PRE1) return "R3";
    if (k == T_EMR) return "R4";
    if (k == T_MRR) return "R5";
    if (k == T_PRE2) return "R7";
    if (k == T_REF1 || k == T_REF2) return "R8";
    if (k == T_MRS) return "R9";
    return "R10";
  endfunction

  function automatic logic [3:0] exp_cmd(int k);
    if (k == T_PRE1 || k == T_PRE2) return 4'b0010;
    if (k == T_EMR || k == T_MRR || k == T_MRS) return 4'b0000;
    if (k == T_REF1 || k == T_REF2) return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic logic [1:0] exp_ba(int k);
    return (k == T_EMR) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [AW-1:0] exp_addr(int k);
    if (k == T_PRE1 || k == T_PRE2) return AW'(1) << 10;
    if (k == T_EMR) return EMR;
    if (k == T_MRR) return MR | (AW'(1) << 8);
    if (k == T_MRS) return MR & ~(AW'(1) << 8);
    return '0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_cycle(int k);
    string t = tag_of(k);
    chk((k < P) ? "R1" : "R2", "cke", 32'(cke), 32'(k >= P));
    chk(t, "cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'(exp_cmd(k)));
    chk(t, "ba", 32'(ba), 32'(exp_ba(k)));
    chk(t, "addr", 32'(addr), 32'(exp_addr(k)));
    chk((k > T_DONE) ? "R11" : "R9", "init_done", 32'(init_done), 32'(k >= T_DONE));
    chk("R6", "read_ok", 32'(read_ok), 32'(k >= T_RDOK));
  endtask

  task automatic check_reset(string tag);
    chk(tag, "reset cke", 32'(cke), 0);
    chk(tag, "reset cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
    chk(tag, "reset init_done", 32'(init_done), 0);
    chk(tag, "reset read_ok", 32'(read_ok), 0);
  endtask

  task automatic run(int len);
    @(negedge clk);
    rst_n = 1;
    #1 check_cycle(0);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      #1 check_cycle(k);
    end
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1 check_reset("R12");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 check_reset("R1");
    run(FULL);
    run(T_MRR + 5);
    run(T_RDOK);
    run(P - 1);
    for (int i = 0; i < 6; i++) begin
      run(int'($urandom_range(1, FULL)));
    end
    run(FULL);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule